// File: doc/BRIEF.md
# ARINC 429 Self-Test Word Serializer

This block turns a 32-bit test word into a serial ARINC 429 symbol stream. A single load strobe captures the word together with a speed select. Transmission starts on its own at once, at the rate sampled with that strobe. Each bit is sent as a bipolar return-to-zero symbol on two digital outputs, `tx1_o` and `tx0_o`, which feed an external line driver. The least significant bit goes first.

The same bit sequence is also presented as a loopback stream, a data bit plus a one-cycle valid pulse per bit. Every receive channel gets this stream for self-test. The symbols always appear on the two outputs, whatever the receivers do with the loopback copy.

Once the last bit has gone out, the block holds the line at NULL for a fixed gap and then releases its busy flag. A load request that arrives while busy is dropped. Bit timing is derived from the system clock by an integer half-bit divider.

Top module: `selftest_serializer`

## Requirements
- R1: After reset, `busy_o` is 0, both `tx1_o` and `tx0_o` are 0 (NULL), and `lb_valid_o` is 0.
- R2: Symbols are encoded on {`tx1_o`,`tx0_o`} as 10 for a one bit, 01 for a zero bit and 00 for NULL. The code 11 never appears.
- R3: Bits leave least significant first. `word_i[0]` is sent first and `word_i[31]` is sent last.
- R4: When `load_i` is 1 at a clock edge while idle, `busy_o` is 1 from the next cycle and the first data symbol is on the outputs in that same cycle.
- R5: Each bit lasts 2·H cycles: the data symbol for H cycles, then NULL for H cycles. H is `HALF_HI` when `slow_i` was 0 at load, and `HALF_HI`·`LOW_RATIO` when it was 1.
- R6: The rate is fixed at load time. Changes on `slow_i` during a transmission do not change its timing.
- R7: After the 32nd bit, the outputs stay NULL for `TRAIL_BITS` (4) bit times with `busy_o` still 1. `busy_o` falls after 2·H·36 cycles in total.
- R8: A `load_i` pulse while `busy_o` is 1 is ignored. The word in flight continues unchanged and no new word follows it.
- R9: `lb_valid_o` pulses for exactly one cycle, the first cycle of each data half, 32 times per word. `lb_data_o` holds that bit in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load strobe; starts a transmission when idle |
| word_i | input | 32 | Test word captured with the strobe |
| slow_i | input | 1 | Rate select at load: 0 high rate, 1 low rate |
| tx1_o | output | 1 | Symbol output, high for a one bit |
| tx0_o | output | 1 | Symbol output, high for a zero bit |
| lb_data_o | output | 1 | Loopback bit for the receive channels |
| lb_valid_o | output | 1 | One-cycle pulse marking a new loopback bit |
| busy_o | output | 1 | Transmission or trailing gap in progress |

## Verification
The bench sends all-ones, all-zeros, single-one-at-LSB and single-one-at-MSB words. These show whether the one and zero encodings are distinct and whether the bit order is reversed. Random words at random rates confirm that the half-bit timing follows the rate captured at load. On some words the bench also pulses a second load with the inverted word and flips `slow_i` mid-flight. A correct design shows no trace of either in the cycle-by-cycle symbol trace, the loopback pulses or the busy length.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    localparam int WORD_W     = 32;
    localparam int TRAIL_BITS = 4;
    localparam int IDX_W      = $clog2(WORD_W);
    localparam int TRAIL_W    = $clog2(2 * TRAIL_BITS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARK,
        ST_SPACE,
        ST_TRAIL
    } tx_state_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } sym_t;

    localparam sym_t SYM_NULL = '{hi: 1'b0, lo: 1'b0};
    localparam sym_t SYM_ONE  = '{hi: 1'b1, lo: 1'b0};
    localparam sym_t SYM_ZERO = '{hi: 1'b0, lo: 1'b1};

    function automatic sym_t encode_bit(input logic b);
        return b ? SYM_ONE : SYM_ZERO;
    endfunction

endpackage

// File: rtl/a429_half_timer.sv
module a429_half_timer #(
    parameter int HALF_HI   = 625,
    parameter int LOW_RATIO = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic slow,
    output logic tick
);
    localparam int HALF_LO = HALF_HI * LOW_RATIO;
    localparam int CW      = $clog2(HALF_LO + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = slow ? CW'(HALF_LO - 1) : CW'(HALF_HI - 1);
    assign tick = !hold && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || hold || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/a429_word_shifter.sv
module a429_word_shifter
    import a429_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic              lsb
);
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)        sr <= '0;
        else if (load)  sr <= din;
        else if (shift) sr <= {1'b0, sr[WORD_W-1:1]};
    end

    assign lsb = sr[0];
endmodule

// File: rtl/a429_symbol_enc.sv
module a429_symbol_enc
    import a429_tx_pkg::*;
(
    input  logic mark,
    input  logic bit_val,
    output sym_t sym
);
    always_comb begin
        if (mark) sym = encode_bit(bit_val);
        else      sym = SYM_NULL;
    end
endmodule

// File: rtl/selftest_serializer.sv
module selftest_serializer
    import a429_tx_pkg::*;
#(
    parameter int HALF_HI   = 625,
    parameter int LOW_RATIO = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load_i,
    input  logic [31:0] word_i,
    input  logic        slow_i,
    output logic        tx1_o,
    output logic        tx0_o,
    output logic        lb_data_o,
    output logic        lb_valid_o,
    output logic        busy_o
);
    tx_state_t          state;
    logic [IDX_W-1:0]   bit_idx;
    logic [TRAIL_W-1:0] trail_idx;
    logic               slow_q;
    logic               lb_pulse;
    logic               tick;
    logic               accept;
    logic               do_shift;
    logic               cur_bit;
    sym_t               sym;

    assign accept   = load_i && (state == ST_IDLE);
    assign do_shift = tick && (state == ST_SPACE) && (bit_idx != IDX_W'(WORD_W - 1));

    a429_half_timer #(.HALF_HI(HALF_HI), .LOW_RATIO(LOW_RATIO)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .hold (state == ST_IDLE),
        .slow (slow_q),
        .tick (tick)
    );

    a429_word_shifter u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .shift (do_shift),
        .din   (word_i),
        .lsb   (cur_bit)
    );

    a429_symbol_enc u_enc (
        .mark    (state == ST_MARK),
        .bit_val (cur_bit),
        .sym     (sym)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_idx   <= '0;
            trail_idx <= '0;
            slow_q    <= 1'b0;
            lb_pulse  <= 1'b0;
        end else begin
            lb_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_MARK;
                        bit_idx  <= '0;
                        slow_q   <= slow_i;
                        lb_pulse <= 1'b1;
                    end
                end
                ST_MARK: begin
                    if (tick) state <= ST_SPACE;
                end
                ST_SPACE: begin
                    if (tick) begin
                        if (bit_idx == IDX_W'(WORD_W - 1)) begin
                            state     <= ST_TRAIL;
                            trail_idx <= '0;
                        end else begin
                            state    <= ST_MARK;
                            bit_idx  <= bit_idx + 1'b1;
                            lb_pulse <= 1'b1;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        if (trail_idx == TRAIL_W'(2 * TRAIL_BITS - 1)) state <= ST_IDLE;
                        else trail_idx <= trail_idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx1_o      = sym.hi;
    assign tx0_o      = sym.lo;
    assign lb_data_o  = cur_bit;
    assign lb_valid_o = lb_pulse;
    assign busy_o     = (state != ST_IDLE);
endmodule

// File: rtl/serializer_chk.sv
module serializer_chk (
    input logic clk,
    input logic rst,
    input logic load_i,
    input logic tx1_o,
    input logic tx0_o,
    input logic lb_data_o,
    input logic lb_valid_o,
    input logic busy_o
);
    // R2
    no_illegal_code_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx1_o && tx0_o));

    // R4
    load_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !busy_o) |=> busy_o);

    // R4
    first_symbol_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (lb_valid_o && (tx1_o || tx0_o)));

    // R1
    idle_null_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!tx1_o && !tx0_o && !lb_valid_o));

    // R9
    loopback_match_chk: assert property (@(posedge clk) disable iff (rst)
        lb_valid_o |-> (tx1_o == lb_data_o) && (tx0_o == !lb_data_o));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        lb_valid_o |=> !lb_valid_o);
endmodule

bind selftest_serializer serializer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .tx1_o      (tx1_o),
    .tx0_o      (tx0_o),
    .lb_data_o  (lb_data_o),
    .lb_valid_o (lb_valid_o),
    .busy_o     (busy_o)
);

// File: tb/tb_selftest_serializer.sv
`timescale 1ns/1ps
module tb_selftest_serializer;
    localparam int HH   = 3;
    localparam int LR   = 4;
    localparam int NBIT = 32;
    localparam int TRL  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        slow_i = 1'b0;
    logic        tx1_o, tx0_o, lb_data_o, lb_valid_o, busy_o;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    selftest_serializer #(.HALF_HI(HH), .LOW_RATIO(LR)) dut (
        .clk(clk), .rst(rst), .load_i(load_i), .word_i(word_i), .slow_i(slow_i),
        .tx1_o(tx1_o), .tx0_o(tx0_o), .lb_data_o(lb_data_o),
        .lb_valid_o(lb_valid_o), .busy_o(busy_o)
    );

    function automatic logic [1:0] exp_sym(input logic [31:0] w, input int h, input int c);
        int ph;
        ph = c / h;
        if (ph >= 2 * NBIT || (ph % 2) != 0) return 2'b00;
        return w[ph / 2] ? 2'b10 : 2'b01;
    endfunction

    function automatic logic exp_valid(input int h, input int c);
        return (c / h < 2 * NBIT) && ((c / h) % 2 == 0) && (c % h == 0);
    endfunction

    task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one word; if perturb_at >= 0 a second load with the inverted word
    // and a flipped rate select is driven at that cycle of the transmission.
    task automatic send(input logic [31:0] w, input logic slow, input int perturb_at);
        int h, total, bad_sym, bad_lb, bad_busy, first_c, pulses;
        logic [1:0] act_first, exp_first;
        h = slow ? HH * LR : HH;
        total = 2 * h * (NBIT + TRL);
        bad_sym = 0; bad_lb = 0; bad_busy = 0; first_c = -1; pulses = 0;
        act_first = '0; exp_first = '0;
        @(negedge clk);
        word_i = w; slow_i = slow; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        for (int c = 0; c < total; c++) begin
            if (c == perturb_at) begin
                word_i = ~w; slow_i = ~slow; load_i = 1'b1;
            end else if (c == perturb_at + 1) begin
                load_i = 1'b0;
            end
            if ({tx1_o, tx0_o} !== exp_sym(w, h, c)) begin
                if (first_c < 0) begin
                    first_c = c; act_first = {tx1_o, tx0_o}; exp_first = exp_sym(w, h, c);
                end
                bad_sym++;
            end
            if (lb_valid_o) pulses++;
            if (lb_valid_o !== exp_valid(h, c) ||
                (lb_valid_o && lb_data_o !== w[(c / h) / 2])) bad_lb++;
            if (busy_o !== 1'b1) bad_busy++;
            @(negedge clk);
        end
        load_i = 1'b0;
        // R2 R3 R5 R6 R8: full symbol trace matches, first mismatch reported
        check(perturb_at >= 0 ? "R3/R5 trace (R6 R8 perturbed)" : "R2 R3 R5 symbol trace",
              bad_sym == 0, 64'(act_first), 64'(exp_first));
        // R9 loopback pulses and data
        check("R9 loopback", bad_lb == 0 && pulses == NBIT, 64'(pulses), 64'(NBIT));
        // R4 R7 busy held for whole word and trailing gap
        check("R4 R7 busy during word", bad_busy == 0, 64'(bad_busy), 64'd0);
        // R7 busy falls exactly at the end; R8 no second word follows
        check("R7 R8 idle after gap", busy_o == 1'b0 && tx1_o == 1'b0 && tx0_o == 1'b0,
              64'({busy_o, tx1_o, tx0_o}), 64'd0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1A29;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset state", busy_o == 0 && tx1_o == 0 && tx0_o == 0 && lb_valid_o == 0,
              64'({busy_o, tx1_o, tx0_o, lb_valid_o}), 64'd0);

        // Directed corners
        send(32'hFFFF_FFFF, 1'b0, -1);
        send(32'h0000_0000, 1'b0, -1);
        send(32'h0000_0001, 1'b1, -1);
        send(32'h8000_0000, 1'b0, -1);
        // R8 R6: load of inverted word and rate flip mid-flight
        send(32'hA5C3_0F96, 1'b0, 40);
        send(32'h1234_5678, 1'b1, 5);

        // Constrained random
        for (int i = 0; i < 8; i++) begin
            logic [31:0] w;
            logic s;
            int p;
            w = $urandom;
            s = 1'($urandom % 2);
            p = ($urandom % 3 == 0) ? int'($urandom % 150) + 1 : -1;
            send(w, s, p);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule